// File: doc/BRIEF.md
# Serial Memory Clock Shaper

This block derives the serial clock for an external-RAM serial link from the system clock. An 8-bit divide value N sets the period to N+1 system cycles. Two compare values shape the waveform: the clock is high while an internal count lies above the high-count value and at or below the low-count value. The counter runs from 0 to N and then wraps. A bypass input sends the system clock itself to the output.

The serial clock is gated by chip-select in whole periods. The select input is sampled only when the counter wraps. A two-bit trailing mode decides what happens after chip-select drops: the clock stops at once, or it runs one or two more full periods, or it never stops. A gated clock sits low. Divider settings are taken into shadow registers only at a wrap, so a mid-period change never cuts a pulse short.

Top module: `sclk_shaper`

## Requirements
- R1: With bypass off, the serial clock period is N+1 system cycles, where N is `div_n_i`.
- R2: Within a period the output is high for counts H+1 through L and low otherwise, where H is `hi_cnt_i` and L is `lo_cnt_i`. With the legal settings L=N and H=floor((N+1)/2-1), this gives N-H high cycles and H+1 low cycles.
- R3: After reset the shadow settings are N=3, H=1, L=3, the output is low and the gate is closed.
- R4: With `bypass_i`=1 the output follows the system clock while the gate is open. The divider fields then have no effect.
- R5: Mode 2'b00 keeps the output low while chip-select is inactive. When chip-select drops, only the period already under way completes. Chip-select is sampled at each wrap.
- R6: Mode 2'b01 adds one full period after the period under way. Mode 2'b10 adds two.
- R7: Mode 2'b11 keeps the output running whatever the state of chip-select.
- R8: New divider fields take effect only at the next wrap. The period under way keeps its old shape.
- R9: A gated-off clock is held low. It stops only at the end of a complete period, so every pulse has its full high width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| div_n_i | input | 8 | Divide value N, period N+1 |
| hi_cnt_i | input | 8 | High-count compare value H |
| lo_cnt_i | input | 8 | Low-count compare value L |
| bypass_i | input | 1 | 1: output the system clock |
| trail_mode_i | input | 2 | Trailing-clock mode |
| cs_active_i | input | 1 | Chip-select asserted (active high) |
| sclk_o | output | 1 | Serial clock |

## Verification
The divided output comes from a register, so it changes one system edge after the count moves. The bench samples 2 ns after each rising edge and measures high and low runs in whole samples.

Chip-select takes effect only at the wrap that follows it. The trailing tests therefore release chip-select in the sample where a falling edge is seen. That is the cycle in which the wrap has just decided the period now starting. From that point 1+m pulses are due.

In bypass the gate passes through a falling-edge register. The bench allows three cycles for the gate to settle. It then checks both the high and the low phase of every cycle.

// File: rtl/sclk_shaper_pkg.sv
// Package: shared types and reset constants for the serial clock shaper.
// Assumes: the mode encodings are fixed, because software programs them.
package sclk_shaper_pkg;
    typedef enum logic [1:0] {
        TRAIL_NONE = 2'b00,
        TRAIL_ONE  = 2'b01,
        TRAIL_TWO  = 2'b10,
        TRAIL_FREE = 2'b11
    } trail_mode_e;

    localparam int unsigned CNT_W_DEF = 8;
    localparam int unsigned RST_N_DIV = 3;
    localparam int unsigned RST_H_CNT = 1;
    localparam int unsigned RST_L_CNT = 3;
endpackage

// File: rtl/sclk_div_core.sv
// Module: period counter and waveform register.
// What it does: counts from 0 to the shadowed N, drives its output high for
// counts in (H, L], and loads new settings only at a wrap.
// Assumes: L <= N and H < L for a useful waveform. In bypass the counter is
// held at zero and every cycle counts as a wrap.
module sclk_div_core
    import sclk_shaper_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEF,
    parameter int unsigned DEF_N = RST_N_DIV,
    parameter int unsigned DEF_H = RST_H_CNT,
    parameter int unsigned DEF_L = RST_L_CNT
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bypass_i,
    input  logic [CNT_W-1:0] div_n_i,
    input  logic [CNT_W-1:0] hi_cnt_i,
    input  logic [CNT_W-1:0] lo_cnt_i,
    output logic             wrap_o,
    output logic             div_o
);
    localparam logic [CNT_W-1:0] RST_N = CNT_W'(DEF_N);
    localparam logic [CNT_W-1:0] RST_H = CNT_W'(DEF_H);
    localparam logic [CNT_W-1:0] RST_L = CNT_W'(DEF_L);

    logic [CNT_W-1:0] cnt_q, n_q, h_q, l_q;
    logic [CNT_W-1:0] cnt_nx;
    logic             div_q;

    // Purpose: flag the last count of a period, or every cycle in bypass.
    always_comb begin
        wrap_o = bypass_i || (cnt_q == n_q);
        cnt_nx = cnt_q + 1'b1;
    end

    // Purpose: step the counter, refresh the shadows at a wrap, form the waveform.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            n_q   <= RST_N;
            h_q   <= RST_H;
            l_q   <= RST_L;
            div_q <= 1'b0;
        end else if (wrap_o) begin
            cnt_q <= '0;
            n_q   <= div_n_i;
            h_q   <= hi_cnt_i;
            l_q   <= lo_cnt_i;
            div_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nx;
            div_q <= (cnt_nx > h_q) && (cnt_nx <= l_q);
        end
    end

    assign div_o = div_q;

    // R1: the count never passes the divide value that is in force.
    a_r1_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= n_q);
    // R2: a rising edge appears only inside the (H, L] window.
    a_r2_rise_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(div_q) |-> (cnt_q > h_q) && (cnt_q <= l_q));
    // R2: a falling edge appears only past L or at a wrap.
    a_r2_fall_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(div_q) |-> (cnt_q == '0) || (cnt_q == l_q + 1'b1));
    // R8: the shadow settings hold between wraps.
    a_r8_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap_o |=> $stable(n_q) && $stable(h_q) && $stable(l_q));
endmodule

// File: rtl/sclk_gate_ctl.sv
// Module: chip-select gate with trailing periods.
// What it does: at every wrap it decides whether the coming period is sent
// out. It counts down the trailing periods left after chip-select drops.
// Assumes: wrap_i marks the cycle before count zero. Chip-select is held for
// at least one period, since it is sampled only at a wrap.
module sclk_gate_ctl
    import sclk_shaper_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wrap_i,
    input  logic        cs_i,
    input  trail_mode_e mode_i,
    output logic        gate_o
);
    logic [1:0] trail_q;
    logic       gate_q;

    // Purpose: update the gate and the trailing budget at period boundaries.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            gate_q  <= 1'b0;
            trail_q <= 2'd0;
        end else if (wrap_i) begin
            if (cs_i) begin
                gate_q  <= 1'b1;
                trail_q <= (mode_i == TRAIL_FREE) ? 2'd0 : 2'(mode_i);
            end else if (mode_i == TRAIL_FREE) begin
                gate_q <= 1'b1;
            end else if (trail_q != 2'd0) begin
                gate_q  <= 1'b1;
                trail_q <= trail_q - 2'd1;
            end else begin
                gate_q <= 1'b0;
            end
        end
    end

    assign gate_o = gate_q;

    // R5: a wrap with chip-select asserted opens the next period.
    a_r5_open_on_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap_i && cs_i) |=> gate_q);
    // R5: with no budget left and select off, the gate closes.
    a_r5_close_when_spent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap_i && !cs_i && mode_i != TRAIL_FREE && trail_q == 2'd0) |=> !gate_q);
    // R6: the trailing budget never grows without chip-select.
    a_r6_budget_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cs_i |=> trail_q <= $past(trail_q));
    // R7: free-running mode always keeps the gate open after a wrap.
    a_r7_free_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap_i && mode_i == TRAIL_FREE) |=> gate_q);
    // R9: the gate moves only at period boundaries.
    a_r9_gate_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap_i |=> $stable(gate_q));
endmodule

// File: rtl/sclk_shaper.sv
// Module: top of the serial clock shaper.
// What it does: joins the divider core and the gate control. In bypass it
// passes the system clock through, gated by a copy of the gate captured on
// the falling edge.
// Assumes: bypass changes only while the gate is closed, since the output
// mux is combinational.
module sclk_shaper
    import sclk_shaper_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] div_n_i,
    input  logic [CNT_W-1:0] hi_cnt_i,
    input  logic [CNT_W-1:0] lo_cnt_i,
    input  logic             bypass_i,
    input  logic [1:0]       trail_mode_i,
    input  logic             cs_active_i,
    output logic             sclk_o
);
    logic        wrap, div_q, gate_q, gate_neg_q;
    trail_mode_e mode;

    assign mode = trail_mode_e'(trail_mode_i);

    sclk_div_core #(.CNT_W(CNT_W)) u_core (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .bypass_i (bypass_i),
        .div_n_i  (div_n_i),
        .hi_cnt_i (hi_cnt_i),
        .lo_cnt_i (lo_cnt_i),
        .wrap_o   (wrap),
        .div_o    (div_q)
    );

    sclk_gate_ctl u_gate (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wrap_i (wrap),
        .cs_i   (cs_active_i),
        .mode_i (mode),
        .gate_o (gate_q)
    );

    // Purpose: re-time the gate to the low phase so the bypass clock never gets a runt.
    always_ff @(negedge clk_i) begin
        if (!rst_ni) gate_neg_q <= 1'b0;
        else         gate_neg_q <= gate_q;
    end

    // Purpose: choose the bypass clock or the gated divided clock.
    always_comb begin
        if (bypass_i) sclk_o = clk_i & gate_neg_q;
        else          sclk_o = div_q & gate_q;
    end

    // R9: the gate closes only while the divided waveform is low.
    a_r9_close_while_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(gate_q) |-> !div_q);
    // R4: in bypass the divided waveform stays parked low.
    a_r4_core_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(bypass_i) && bypass_i |-> !div_q);
endmodule

// File: tb/sclk_shaper_test.sv
module sclk_shaper_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_n = 8'd3, hi_c = 8'd1, lo_c = 8'd3;
    logic       bypass = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       cs = 1'b0;
    logic       sclk;
    logic       s;
    int         n_chk = 0, n_bad = 0;
    bit         done = 0;

    sclk_shaper uut (
        .clk_i(clk), .rst_ni(rst_n), .div_n_i(div_n), .hi_cnt_i(hi_c),
        .lo_cnt_i(lo_c), .bypass_i(bypass), .trail_mode_i(mode),
        .cs_active_i(cs), .sclk_o(sclk)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // sample 2 ns after the rising edge, in the high phase
    task automatic tick();
        @(posedge clk);
        #2;
        s = sclk;
    endtask

    task automatic run_len(input bit v, output int n);
        n = 0;
        while (s == v && n < 1000) begin
            n++;
            tick();
        end
    endtask

    task automatic measure(output int per, output int hi);
        int lo, skip;
        run_len(1'b1, skip);
        run_len(1'b0, skip);
        run_len(1'b1, hi);
        run_len(1'b0, lo);
        per = hi + lo;
    endtask

    task automatic set_div(input int n, input int h, input int l);
        div_n = 8'(n); hi_c = 8'(h); lo_c = 8'(l);
    endtask

    task automatic t_reset();
        int ones = 0;
        for (int i = 0; i < 4; i++) begin tick(); if (s) ones++; end
        chk("R3 low in reset", ones, 0);
        rst_n = 1'b1;
        ones = 0;
        for (int i = 0; i < 12; i++) begin tick(); if (s) ones++; end
        chk("R5 idle with select off", ones, 0);
        cs = 1'b1;
        ones = 0;
        for (int i = 0; i < 10; i++) begin tick(); if (s) ones++; end
        chk("R3 default divide starts (high samples)", ones > 0 ? 1 : 0, 1);
    endtask

    task automatic t_ratio(input int n, input int h, input int l);
        int per, hi;
        set_div(n, h, l);
        for (int i = 0; i < 2 * (n + 1) + 4; i++) tick();
        measure(per, hi);
        chk($sformatf("R1 period N=%0d", n), per, n + 1);
        chk($sformatf("R2 high width N=%0d", n), hi, l - h);
    endtask

    task automatic t_change_at_wrap();
        int h1, lo, h2, skip;
        set_div(3, 1, 3);
        for (int i = 0; i < 12; i++) tick();
        run_len(1'b0, skip);
        run_len(1'b1, skip); // now at the sample where the wrap just happened
        tick();
        set_div(7, 3, 7);
        run_len(1'b0, skip);
        run_len(1'b1, h1);
        run_len(1'b0, lo);
        run_len(1'b1, h2);
        chk("R8 period under way keeps old high width", h1, 2);
        chk("R8 new low width after wrap", lo, 4);
        chk("R8 new high width after wrap", h2, 4);
        set_div(3, 1, 3);
        for (int i = 0; i < 16; i++) tick();
    endtask

    task automatic t_trail(input int m);
        int rises = 0, ones = 0, run = 0, short_pulses = 0;
        bit prev;
        mode = 2'(m);
        cs = 1'b1;
        for (int i = 0; i < 12; i++) tick();
        while (s == 1'b0) tick();
        while (s == 1'b1) tick();
        cs = 1'b0;
        prev = 1'b0;
        for (int i = 0; i < 60; i++) begin
            tick();
            if (s && !prev) rises++;
            if (s) run++;
            if (!s && prev) begin
                if (run != 2) short_pulses++;
                run = 0;
            end
            prev = s;
        end
        chk($sformatf("R%0d trailing pulses mode %0d", m == 0 ? 5 : 6, m), rises, 1 + m);
        chk("R9 every trailing pulse full width", short_pulses, 0);
        for (int i = 0; i < 20; i++) begin tick(); if (s) ones++; end
        chk("R9 held low after stop", ones, 0);
    endtask

    task automatic t_free();
        int rises = 0;
        bit prev = 1'b0;
        mode = 2'b11;
        cs = 1'b0;
        for (int i = 0; i < 8; i++) tick();
        prev = s;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (s && !prev) rises++;
            prev = s;
        end
        chk("R7 free-run pulses with select off", rises >= 9 ? 1 : 0, 1);
        mode = 2'b00;
        for (int i = 0; i < 12; i++) tick();
    endtask

    task automatic t_bypass();
        int hi_ok = 0, lo_bad = 0, off = 0;
        set_div(9, 4, 9);
        cs = 1'b1;
        mode = 2'b00;
        tick();
        bypass = 1'b1;
        for (int i = 0; i < 3; i++) tick();
        for (int i = 0; i < 8; i++) begin
            tick();
            if (s) hi_ok++;
            #4;
            if (sclk) lo_bad++;
        end
        chk("R4 bypass high phase", hi_ok, 8);
        chk("R4 bypass low phase", lo_bad, 0);
        cs = 1'b0;
        for (int i = 0; i < 3; i++) tick();
        for (int i = 0; i < 8; i++) begin tick(); if (s) off++; end
        chk("R4 bypass gated off by select", off, 0);
        bypass = 1'b0;
        set_div(3, 1, 3);
    endtask

    initial begin
        t_reset();
        t_ratio(3, 1, 3);
        t_ratio(5, 2, 5);
        t_ratio(4, 1, 4);
        t_ratio(1, 0, 1);
        t_change_at_wrap();
        t_trail(0);
        t_trail(1);
        t_trail(2);
        t_free();
        t_bypass();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule